// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Sequencer

This block runs read transactions against a serial flash device on a four-line bidirectional data bus. A request carries a command byte, a 24-bit address, a count of idle (dummy) serial clocks and a byte count. The sequencer lowers chip select and shifts out the command, then the address. It lets the dummy clocks pass with every data pin released, then gathers the returned bytes and hands each one over on a one-cycle strobe.

The lane count is chosen separately for the command, address and data phases from a 3-bit mode code. The same engine therefore covers plain single-line reads, reads whose data returns on two or four lines, reads whose address also travels on two or four lines, and a mode in which even the command uses four lines. Each data pin has its own output-enable, so the pad ring can turn the pins around between phases.

The serial clock is the core clock divided by two, with idle-low polarity. Outputs change when the serial clock falls and inputs are captured when it rises. A request is taken only while the block is idle and the byte count is non-zero.

Top module: `sflash_read_seq`

## Requirements
- R1: `mode` selects the lane widths for command/address/data as follows: 0 = 1/1/1, 1 = 1/1/2, 2 = 1/2/2, 3 = 1/1/4, 4 = 1/4/4, 5 = 4/4/4. Codes 6 and 7 behave as 0. While a phase drives, `sio_oe` enables exactly its lanes: 4'h1, 4'h3 or 4'hF.
- R2: Every phase sends its most significant bit first. With one lane, output bits appear on `sio_o[0]` and returned bits are taken from `sio_i[1]`.
- R3: With two lanes, each serial clock carries an odd/even bit pair with the odd bit on lane 1. Bits 7,5,3,1 therefore use lane 1 and bits 6,4,2,0 use lane 0, and a byte takes four serial clocks.
- R4: With four lanes, lane 3 carries bits 7 and 3, lane 2 carries bits 6 and 2, lane 1 carries bits 5 and 1, and lane 0 carries bits 4 and 0. A byte takes two serial clocks.
- R5: After the address comes exactly `dummy` serial clocks (0 to 15). `sio_oe` is 0 from the first dummy clock through the last data clock.
- R6: Exactly `nbytes` bytes are delivered per request, in arrival order. Each byte is given on `rd_data` with a one-cycle `rd_valid` while chip select is still low.
- R7: `sclk` is low whenever `cs_n` is high. `sio_o` and `sio_oe` change only while `sclk` is low, so they are stable across every rising edge.
- R8: `cs_n` rises after the last byte's final serial clock and stays high for at least 4 core cycles (two serial clock periods) before the next request can lower it.
- R9: A `start` pulse is ignored while `busy` is high or when `nbytes` is 0.
- R10: The address is 24 bits wide and is sent in full. After reset `cs_n` is 1, `sclk` is 0, `sio_oe` is 0 and both `busy` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when idle |
| mode | input | 3 | Lane-width mode code |
| cmd | input | 8 | Command byte |
| addr | input | 24 | Read address |
| dummy | input | 4 | Dummy serial clock count |
| nbytes | input | 8 | Number of bytes to read |
| busy | output | 1 | Transaction in progress |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| sio_o | output | 4 | Data lane output values |
| sio_oe | output | 4 | Data lane output enables |
| sio_i | input | 4 | Data lane input values |
| rd_data | output | 8 | Assembled read byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |

## Verification
A phase counter that is off by one moves every later boundary. It appears at the pins within one serial clock as a wrong total of rising edges in the frame, and as address or returned bits landing on the wrong lanes. A lane width latched wrongly for one phase shows as the wrong `sio_oe` mask on the first clock of that phase. It also scrambles every reconstructed byte. A fault in the turnaround state drives a pin during dummy or data clocks, and the first rising edge exposes it. A broken gap counter shortens the chip-select high time between back-to-back requests.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  // lane widths are encoded as the lane count itself: 1, 2 or 4
  typedef struct packed {
    logic [2:0] cmd_w;
    logic [2:0] addr_w;
    logic [2:0] data_w;
  } lanes_t;

  function automatic lanes_t lanes_of(input logic [2:0] m);
    lanes_t l;
    case (m)
      3'd1:    l = '{cmd_w: 3'd1, addr_w: 3'd1, data_w: 3'd2};
      3'd2:    l = '{cmd_w: 3'd1, addr_w: 3'd2, data_w: 3'd2};
      3'd3:    l = '{cmd_w: 3'd1, addr_w: 3'd1, data_w: 3'd4};
      3'd4:    l = '{cmd_w: 3'd1, addr_w: 3'd4, data_w: 3'd4};
      3'd5:    l = '{cmd_w: 3'd4, addr_w: 3'd4, data_w: 3'd4};
      default: l = '{cmd_w: 3'd1, addr_w: 3'd1, data_w: 3'd1};
    endcase
    return l;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] w);
    case (w)
      3'd4:    return 4'hF;
      3'd2:    return 4'h3;
      default: return 4'h1;
    endcase
  endfunction

endpackage

// File: rtl/sflash_seq_ctl.sv
module sflash_seq_ctl
  import sflash_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int DUM_W     = 4,
  parameter int NB_W      = 8,
  parameter int GAP_CYC   = 4,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic [DUM_W-1:0] dummy,
  input  logic [NB_W-1:0]  nbytes,
  output logic             busy,
  output logic             sclk,
  output logic             cs_n,
  output logic             load,
  output logic             shift,
  output logic             sample,
  output logic             byte_last,
  output logic [2:0]       lane_w,
  output logic [3:0]       drive_mask
);

  localparam int GAP_W = $clog2(GAP_CYC) + 1;

  phase_e           ph_q, ph_d;
  logic             sclk_q, sclk_d;
  logic             cs_q, cs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NB_W-1:0]  left_q, left_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  lanes_t           ln_q;
  logic [DUM_W-1:0] dum_q;
  logic             active, fall, accept;

  function automatic logic [CNT_W-1:0] last_idx(input int bits, input logic [2:0] w);
    case (w)
      3'd4:    return CNT_W'(bits / 4 - 1);
      3'd2:    return CNT_W'(bits / 2 - 1);
      default: return CNT_W'(bits - 1);
    endcase
  endfunction

  assign active = (ph_q == PH_CMD) || (ph_q == PH_ADDR) ||
                  (ph_q == PH_DUMMY) || (ph_q == PH_DATA);
  assign fall   = active && sclk_q;
  assign accept = start && (ph_q == PH_IDLE) && (nbytes != '0);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    gap_d  = gap_q;
    sclk_d = active ? ~sclk_q : 1'b0;
    case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d   = PH_CMD;
        cnt_d  = last_idx(8, lanes_of(mode).cmd_w);
        left_d = nbytes;
      end
      PH_CMD: if (fall) begin
        if (cnt_q == '0) begin
          ph_d  = PH_ADDR;
          cnt_d = last_idx(ADDR_BITS, ln_q.addr_w);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_ADDR: if (fall) begin
        if (cnt_q == '0) begin
          if (dum_q == '0) begin
            ph_d  = PH_DATA;
            cnt_d = last_idx(8, ln_q.data_w);
          end else begin
            ph_d  = PH_DUMMY;
            cnt_d = CNT_W'(dum_q) - 1'b1;
          end
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_DUMMY: if (fall) begin
        if (cnt_q == '0) begin
          ph_d  = PH_DATA;
          cnt_d = last_idx(8, ln_q.data_w);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_DATA: if (fall) begin
        if (cnt_q == '0) begin
          if (left_q == NB_W'(1)) begin
            ph_d  = PH_GAP;
            gap_d = GAP_W'(GAP_CYC - 1);
          end else begin
            left_d = left_q - 1'b1;
            cnt_d  = last_idx(8, ln_q.data_w);
          end
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_GAP: begin
        if (gap_q == '0) ph_d = PH_IDLE;
        else gap_d = gap_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
    cs_d = (ph_d == PH_IDLE) || (ph_d == PH_GAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt_q  <= '0;
      left_q <= '0;
      gap_q  <= '0;
      ln_q   <= '0;
      dum_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      gap_q  <= gap_d;
      if (accept) begin
        ln_q  <= lanes_of(mode);
        dum_q <= dummy;
      end
    end
  end

  always_comb begin
    case (ph_q)
      PH_CMD:  lane_w = ln_q.cmd_w;
      PH_ADDR: lane_w = ln_q.addr_w;
      PH_DATA: lane_w = ln_q.data_w;
      default: lane_w = 3'd1;
    endcase
  end

  assign drive_mask = ((ph_q == PH_CMD) || (ph_q == PH_ADDR)) ? lane_mask(lane_w) : 4'h0;
  assign load       = accept;
  assign shift      = fall && ((ph_q == PH_CMD) || (ph_q == PH_ADDR));
  assign sample     = (ph_q == PH_DATA) && !sclk_q;
  assign byte_last  = (cnt_q == '0);
  assign busy       = (ph_q != PH_IDLE);
  assign sclk       = sclk_q;
  assign cs_n       = cs_q;

endmodule

// File: rtl/sflash_tx_shift.sv
module sflash_tx_shift #(
  parameter int SH_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SH_W-1:0] load_val,
  input  logic            shift,
  input  logic [2:0]      lane_w,
  input  logic [3:0]      drive_mask,
  output logic [3:0]      sio_o
);

  logic [SH_W-1:0] sh_q, sh_d;
  logic [3:0]      top4, raw;

  always_comb begin
    sh_d = sh_q;
    if (load) sh_d = load_val;
    else if (shift) begin
      case (lane_w)
        3'd4:    sh_d = sh_q << 4;
        3'd2:    sh_d = sh_q << 2;
        default: sh_d = sh_q << 1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (load || shift) sh_q <= sh_d;
  end

  assign top4 = sh_q[SH_W-1 -: 4];

  always_comb begin
    case (lane_w)
      3'd4:    raw = top4;
      3'd2:    raw = {2'b00, top4[3:2]};
      default: raw = {3'b000, top4[3]};
    endcase
  end

  assign sio_o = raw & drive_mask;

endmodule

// File: rtl/sflash_rx_asm.sv
module sflash_rx_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic       byte_last,
  input  logic [2:0] lane_w,
  input  logic [3:0] sio_i,
  output logic [7:0] rd_data,
  output logic       rd_valid
);

  logic [7:0] acc_q, acc_d;
  logic [7:0] data_q;
  logic       vld_q;

  always_comb begin
    case (lane_w)
      3'd4:    acc_d = {acc_q[3:0], sio_i[3:0]};
      3'd2:    acc_d = {acc_q[5:0], sio_i[1:0]};
      default: acc_d = {acc_q[6:0], sio_i[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= sample && byte_last;
      if (sample) acc_q <= acc_d;
      if (sample && byte_last) data_q <= acc_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = vld_q;

endmodule

// File: rtl/sflash_read_seq.sv
module sflash_read_seq
  import sflash_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int DUM_W     = 4,
  parameter int NB_W      = 8,
  parameter int GAP_CYC   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           mode,
  input  logic [7:0]           cmd,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DUM_W-1:0]     dummy,
  input  logic [NB_W-1:0]      nbytes,
  output logic                 busy,
  output logic                 sclk,
  output logic                 cs_n,
  output logic [3:0]           sio_o,
  output logic [3:0]           sio_oe,
  input  logic [3:0]           sio_i,
  output logic [7:0]           rd_data,
  output logic                 rd_valid
);

  localparam int SH_W  = 8 + ADDR_BITS;
  localparam int CNT_W = $clog2(ADDR_BITS + (1 << DUM_W));

  logic [1:0] rs_q;
  logic       core_rst_n;
  logic       load, shift, sample, byte_last;
  logic [2:0] lane_w;
  logic [3:0] drive_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  sflash_seq_ctl #(
    .ADDR_BITS(ADDR_BITS), .DUM_W(DUM_W), .NB_W(NB_W),
    .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst_n(core_rst_n), .start(start), .mode(mode),
    .dummy(dummy), .nbytes(nbytes), .busy(busy), .sclk(sclk),
    .cs_n(cs_n), .load(load), .shift(shift), .sample(sample),
    .byte_last(byte_last), .lane_w(lane_w), .drive_mask(drive_mask)
  );

  sflash_tx_shift #(.SH_W(SH_W)) u_tx (
    .clk(clk), .rst_n(core_rst_n), .load(load), .load_val({cmd, addr}),
    .shift(shift), .lane_w(lane_w), .drive_mask(drive_mask), .sio_o(sio_o)
  );

  sflash_rx_asm u_rx (
    .clk(clk), .rst_n(core_rst_n), .sample(sample), .byte_last(byte_last),
    .lane_w(lane_w), .sio_i(sio_i), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign sio_oe = drive_mask;

endmodule

// File: rtl/sflash_read_seq_chk.sv
module sflash_read_seq_chk #(
  parameter int ADDR_BITS = 24,
  parameter int DUM_W     = 4,
  parameter int NB_W      = 8,
  parameter int GAP_CYC   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [2:0]           mode,
  input logic [7:0]           cmd,
  input logic [ADDR_BITS-1:0] addr,
  input logic [DUM_W-1:0]     dummy,
  input logic [NB_W-1:0]      nbytes,
  input logic                 busy,
  input logic                 sclk,
  input logic                 cs_n,
  input logic [3:0]           sio_o,
  input logic [3:0]           sio_oe,
  input logic [3:0]           sio_i,
  input logic [7:0]           rd_data,
  input logic                 rd_valid
);

  logic [3:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 4'hF;
    else if (!cs_n) hi_cnt <= 4'h0;
    else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 4'h1;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R7
  AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(sio_o) && $stable(sio_oe))); // R7
  AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe == 4'h0) || (sio_oe == 4'h1) || (sio_oe == 4'h3) || (sio_oe == 4'hF)); // R1
  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (sio_oe == 4'h0)); // R5
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!cs_n && busy)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 4'd4)); // R8
  AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R9

endmodule

bind sflash_read_seq sflash_read_seq_chk #(
  .ADDR_BITS(ADDR_BITS), .DUM_W(DUM_W), .NB_W(NB_W), .GAP_CYC(GAP_CYC)
) u_chk (.*);

// File: tb/sim_sflash_read_seq.sv
module sim_sflash_read_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  cmd = '0;
  logic [23:0] addr = '0;
  logic [3:0]  dummy = '0;
  logic [7:0]  nbytes = '0;
  logic [3:0]  sio_i = '0;
  logic        busy, sclk, cs_n, rd_valid;
  logic [3:0]  sio_o, sio_oe;
  logic [7:0]  rd_data;

  always #10 clk = ~clk;

  sflash_read_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cmd(cmd),
    .addr(addr), .dummy(dummy), .nbytes(nbytes), .busy(busy), .sclk(sclk),
    .cs_n(cs_n), .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(sio_i),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rise_n = 0, n_got = 0, gap_cnt = 100, last_gap = 100, hold_bad = 0;
  int data_start = 0, wdat = 1, g_seed = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [3:0] prev_o = '0;
  logic [3:0] rec_o [0:511];
  logic [3:0] rec_oe [0:511];
  logic [7:0] got [0:63];

  function automatic int wc_of(input int m); return (m == 5) ? 4 : 1; endfunction
  function automatic int wa_of(input int m);
    return (m == 2) ? 2 : ((m == 4 || m == 5) ? 4 : 1);
  endfunction
  function automatic int wd_of(input int m);
    return (m == 1 || m == 2) ? 2 : ((m >= 3 && m <= 5) ? 4 : 1);
  endfunction
  function automatic logic [3:0] mask_of(input int w);
    return (w == 4) ? 4'hF : ((w == 2) ? 4'h3 : 4'h1);
  endfunction
  function automatic logic [7:0] sb(input int k);
    return 8'(((k + g_seed) * 91 + 23) ^ 166);
  endfunction
  function automatic int chunk(input logic [3:0] o, input int w);
    return (w == 4) ? int'(o) : ((w == 2) ? int'(o[1:0]) : int'(o[0]));
  endfunction

  function automatic logic [3:0] slave_nib(input int c);
    int rel, cpb, ch;
    logic [7:0] b, v;
    if (c < data_start) return 4'h0;
    rel = c - data_start;
    cpb = 8 / wdat;
    b   = sb(rel / cpb);
    ch  = rel % cpb;
    v   = (b >> (8 - wdat * (ch + 1))) & 8'((1 << wdat) - 1);
    if (wdat == 1) return {2'b00, v[0], 1'b0};
    return v[3:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // flash model and pin monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      rise_n   = 0;
      last_gap = gap_cnt;
    end
    if (cs_n) gap_cnt++; else gap_cnt = 0;
    if (cs_n && sclk) hold_bad++;
    if (sclk && !prev_sclk) begin
      if (sio_o !== prev_o) hold_bad++;
      rec_o[rise_n]  = sio_o;
      rec_oe[rise_n] = sio_oe;
      rise_n++;
    end
    if (!sclk && prev_sclk) sio_i = slave_nib(rise_n);
    if (rd_valid) begin
      got[n_got] = rd_data;
      n_got++;
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
    prev_o    = sio_o;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      report();
      $finish;
    end
  end

  task automatic launch(input int m, input logic [7:0] c, input logic [23:0] a,
                        input int d, input int n, input int seed);
    g_seed     = seed;
    wdat       = wd_of(m);
    data_start = 8 / wc_of(m) + 24 / wa_of(m) + d;
    n_got      = 0;
    @(negedge clk);
    mode   = 3'(m);
    cmd    = c;
    addr   = a;
    dummy  = 4'(d);
    nbytes = 8'(n);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int m, input logic [7:0] c,
                             input logic [23:0] a, input int d, input int n);
    int wc, wa, wd, p, val, oe_bad;
    wc = wc_of(m);
    wa = wa_of(m);
    wd = wd_of(m);
    chk({req, " R1 clock count"}, rise_n, 8 / wc + 24 / wa + d + n * (8 / wd));
    p = 0; val = 0; oe_bad = 0;
    for (int i = 0; i < 8 / wc; i++) begin
      val = (val << wc) | chunk(rec_o[p + i], wc);
      if (rec_oe[p + i] !== mask_of(wc)) oe_bad++;
    end
    p += 8 / wc;
    chk({req, " R2 command bits"}, val, int'(c));
    val = 0;
    for (int i = 0; i < 24 / wa; i++) begin
      val = (val << wa) | chunk(rec_o[p + i], wa);
      if (rec_oe[p + i] !== mask_of(wa)) oe_bad++;
    end
    p += 24 / wa;
    chk({req, " R10 address bits"}, val, int'(a));
    chk({req, " R1 drive mask"}, oe_bad, 0);
    oe_bad = 0;
    for (int i = p; i < rise_n; i++) if (rec_oe[i] !== 4'h0) oe_bad++;
    chk({req, " R5 released pins"}, oe_bad, 0);
    chk({req, " R6 byte count"}, n_got, n);
    for (int k = 0; k < n; k++) chk({req, " data byte"}, int'(got[k]), int'(sb(k)));
    chk({req, " R8 cs_n high after"}, int'(cs_n), 1);
  endtask

  task automatic t_reset;
    chk("R10 cs_n", int'(cs_n), 1);
    chk("R10 sclk", int'(sclk), 0);
    chk("R10 sio_oe", int'(sio_oe), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_single;
    launch(0, 8'h03, 24'h123456, 0, 3, 1);
    wait_done();
    check_frame("R2 single", 0, 8'h03, 24'h123456, 0, 3);
  endtask

  task automatic t_dual_out;
    launch(1, 8'h3B, 24'hABCDEF, 8, 4, 7);
    wait_done();
    check_frame("R3 dual data", 1, 8'h3B, 24'hABCDEF, 8, 4);
  endtask

  task automatic t_dual_io;
    launch(2, 8'hBB, 24'h5A5AC3, 4, 2, 12);
    wait_done();
    check_frame("R3 dual addr", 2, 8'hBB, 24'h5A5AC3, 4, 2);
  endtask

  task automatic t_quad_out;
    launch(3, 8'h6B, 24'h0F1E2D, 8, 4, 33);
    wait_done();
    check_frame("R4 quad data", 3, 8'h6B, 24'h0F1E2D, 8, 4);
  endtask

  task automatic t_quad_io;
    launch(4, 8'hEB, 24'hF00F96, 6, 3, 50);
    wait_done();
    check_frame("R4 quad addr", 4, 8'hEB, 24'hF00F96, 6, 3);
  endtask

  task automatic t_all_quad;
    launch(5, 8'h0B, 24'h81C3E7, 2, 2, 77);
    wait_done();
    check_frame("R1 quad cmd", 5, 8'h0B, 24'h81C3E7, 2, 2);
  endtask

  task automatic t_dummy_edges;
    launch(4, 8'hE7, 24'h000001, 0, 1, 90);
    wait_done();
    check_frame("R5 zero dummy", 4, 8'hE7, 24'h000001, 0, 1);
    launch(1, 8'h3B, 24'hFFFFFE, 15, 1, 101);
    wait_done();
    check_frame("R5 max dummy", 1, 8'h3B, 24'hFFFFFE, 15, 1);
  endtask

  task automatic t_busy_ignore;
    launch(0, 8'h03, 24'h456789, 0, 2, 140);
    repeat (30) @(negedge clk);
    mode   = 3'd5;
    cmd    = 8'hFF;
    nbytes = 8'd1;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_frame("R9 busy start", 0, 8'h03, 24'h456789, 0, 2);
    repeat (10) @(negedge clk);
    chk("R9 no second frame busy", int'(busy), 0);
    chk("R9 no second frame cs_n", int'(cs_n), 1);
  endtask

  task automatic t_zero_count;
    @(negedge clk);
    nbytes = 8'd0;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 zero count busy", int'(busy), 0);
    chk("R9 zero count cs_n", int'(cs_n), 1);
  endtask

  task automatic t_back_to_back;
    launch(3, 8'h6B, 24'h2468AC, 2, 1, 160);
    wait_done();
    launch(2, 8'hBB, 24'h13579B, 0, 1, 170);
    wait_done();
    check_frame("R8 second frame", 2, 8'hBB, 24'h13579B, 0, 1);
    chk("R8 chip select gap", int'(last_gap >= 4), 1);
    chk("R7 pins stable at rise, clock low when idle", hold_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_dual_out();
    t_dual_io();
    t_quad_out();
    t_quad_io();
    t_all_quad();
    t_dummy_edges();
    t_busy_ignore();
    t_zero_count();
    t_back_to_back();
    report();
    $finish;
  end

endmodule